// File: doc/BRIEF.md
# Flash Page Erase Sequencer

This block models the erase path of an on-chip flash array. Software clears flash through a short run of register steps instead of one command. It arms erase mode in a control register, reads the block-protect register, and writes to any byte of the target page to latch that page. It then raises the high-voltage enable, drops the erase-mode bit and finally drops the high-voltage enable. The hardware checks that each step arrives in this order and that a minimum number of clock cycles has passed between the timed steps. If the whole run is correct, it fills the latched page, or the whole array in mass mode, with 0xFF.

The minimum delays are derived from a clock-frequency parameter: 10 us, 1 ms or 4 ms, 5 us and 1 us. A step that comes too early or out of order sets a sticky error flag and cancels the erase. Other accesses may occur between the steps. A busy flag spans the high-voltage phase and the recovery time. Array reads during busy return 0xFF and raise a blocked flag.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, the control register reads 0, busy and seq_err are 0, and array byte a holds {1'b0, a[6:0]}.
- R2: The control register (reg_sel=0) has these fields: bit0 program-select, bit1 erase-select, bit2 mass-select, bit3 high-voltage enable, bit4 long-erase select. Bits 7:5 read 0. Reading with reg_sel=1 returns the protect value (default 0xFE).
- R3: Program-select and erase-select never read 1 together. A write that sets both keeps the previous value of each bit.
- R4: An erase happens only in this order: erase-select set, protect register read, array write (which latches the page), high-voltage enable set, erase-select cleared. Setting the high-voltage enable before the page is latched sets seq_err, and no byte changes.
- R5: Setting the high-voltage enable fewer than ceil(CLK_HZ/100000) cycles after the latching write sets seq_err and cancels the erase.
- R6: Clearing erase-select fewer than ceil(CLK_HZ/1000) cycles after the high-voltage enable was set sets seq_err and cancels the erase. With long-erase select set, the limit is four times that count.
- R7: Clearing the high-voltage enable fewer than ceil(CLK_HZ/200000) cycles after erase-select was cleared sets seq_err. An erase that has already completed stays in effect.
- R8: A page erase sets all 64 bytes of the aligned page that holds the latched address to 0xFF and leaves every other byte unchanged. erase_strobe pulses for one cycle after the edge that clears erase-select.
- R9: The top VEC_BYTES (48) bytes of the array form a separate page. Erasing it also clears the trim byte at its lowest address. The 64-byte page that overlaps it covers only the bytes below that region.
- R10: With mass-select set, a correct sequence sets every byte of the array to 0xFF.
- R11: busy is 1 from the edge that sets the high-voltage enable until ceil(CLK_HZ/1000000) cycles after the edge that clears it. While busy, array reads return 0xFF and rd_blocked is 1.
- R12: Control reads and array reads between steps do not abort the sequence. Array writes outside the latching step leave the array unchanged.
- R13: seq_err stays 1 until reset. A later correct sequence still erases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = control register, 1 = protect register |
| reg_wdata | input | 5 | Control register write data |
| reg_rdata | output | 8 | Register read data |
| arr_wr | input | 1 | Array write strobe (data is ignored) |
| arr_rd | input | 1 | Array read strobe |
| arr_addr | input | ADDR_W | Array byte address |
| arr_rdata | output | 8 | Array read data |
| rd_blocked | output | 1 | Read attempted while busy |
| busy | output | 1 | High-voltage or recovery phase active |
| seq_err | output | 1 | Sticky sequence error |
| erase_strobe | output | 1 | One-cycle erase pulse |

## Verification
The assertions check on every cycle that the program and erase bits never read 1 together. They also check that the error flag never drops outside reset, that an erase pulse occurs only while busy and after the erase bit has gone low, and that reads during busy are blocked and return 0xFF. Only the bench scenarios can show that the delay limits are exact to the cycle in each direction and that the long mode quadruples the erase time. The same holds for which bytes a page, vector-page or mass erase touches, and for accesses between steps leaving the sequence intact.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int CLK_HZ = 1_000_000,
  parameter int ADDR_W = 10,
  parameter int VEC_BYTES = 48,
  parameter logic [7:0] PROT_VAL = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [4:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              arr_wr,
  input  logic              arr_rd,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_rdata,
  output logic              rd_blocked,
  output logic              busy,
  output logic              seq_err,
  output logic              erase_strobe
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int NVS      = (CLK_HZ + 99_999) / 100_000;
  localparam int ERS_S    = (CLK_HZ + 999) / 1000;
  localparam int ERS_L    = 4 * ERS_S;
  localparam int NVH      = (CLK_HZ + 199_999) / 200_000;
  localparam int RCV      = (CLK_HZ + 999_999) / 1_000_000;
  localparam int CW       = $clog2(ERS_L + 1) + 1;
  localparam logic [ADDR_W-1:0] VB = ADDR_W'(DEPTH - VEC_BYTES);
  localparam logic [CW-1:0] NVS_C = CW'(NVS);
  localparam logic [CW-1:0] ERSS_C = CW'(ERS_S);
  localparam logic [CW-1:0] ERSL_C = CW'(ERS_L);
  localparam logic [CW-1:0] NVH_C = CW'(NVH);
  localparam logic [CW-1:0] RCV_C = CW'(RCV);

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_PROT, S_LATCH, S_HVON, S_EOFF, S_RECOV} st_t;

  st_t st;
  logic pgm_q, erase_q, mass_q, hven_q, long_q;
  logic abort_q;
  logic [CW-1:0] cnt;
  logic [ADDR_W-1:0] la;
  logic [7:0] mem [DEPTH];

  wire ctrl_wr = reg_wr & ~reg_sel;
  wire prot_rd = reg_rd & reg_sel;
  wire both    = reg_wdata[0] & reg_wdata[1];
  wire pgm_n   = ctrl_wr ? (both ? pgm_q : reg_wdata[0]) : pgm_q;
  wire erase_n = ctrl_wr ? (both ? erase_q : reg_wdata[1]) : erase_q;
  wire hven_n  = ctrl_wr ? reg_wdata[3] : hven_q;
  wire erase_rise = ~erase_q & erase_n;
  wire erase_fall = erase_q & ~erase_n;
  wire hven_rise  = ~hven_q & hven_n;
  wire hven_fall  = hven_q & ~hven_n;
  wire [CW-1:0] ers_need = long_q ? ERSL_C : ERSS_C;

  assign busy       = (st == S_HVON) || (st == S_EOFF) || (st == S_RECOV);
  assign reg_rdata  = reg_sel ? PROT_VAL : {3'b000, long_q, hven_q, mass_q, erase_q, pgm_q};
  assign arr_rdata  = busy ? 8'hFF : mem[arr_addr];
  assign rd_blocked = arr_rd & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {pgm_q, erase_q, mass_q, hven_q, long_q} <= '0;
    end else if (ctrl_wr) begin
      pgm_q   <= pgm_n;
      erase_q <= erase_n;
      mass_q  <= reg_wdata[2];
      hven_q  <= reg_wdata[3];
      long_q  <= reg_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      la <= '0;
      abort_q <= 1'b0;
      seq_err <= 1'b0;
      erase_strobe <= 1'b0;
    end else begin
      erase_strobe <= 1'b0;
      if (cnt != '1) cnt <= cnt + 1'b1;
      unique case (st)
        S_IDLE, S_ARMED, S_PROT: begin
          if (hven_rise) begin
            seq_err <= 1'b1;
            abort_q <= 1'b1;
            st <= S_HVON;
            cnt <= CW'(1);
          end else if (st == S_IDLE) begin
            if (erase_rise) st <= S_ARMED;
          end else if (!erase_n) begin
            st <= S_IDLE;
          end else if (st == S_ARMED && prot_rd) begin
            st <= S_PROT;
          end else if (st == S_PROT && arr_wr) begin
            la <= arr_addr;
            st <= S_LATCH;
            cnt <= CW'(1);
          end
        end
        S_LATCH: begin
          if (hven_rise) begin
            if (cnt < NVS_C) begin
              seq_err <= 1'b1;
              abort_q <= 1'b1;
            end
            st <= S_HVON;
            cnt <= CW'(1);
          end else if (!erase_n) begin
            st <= S_IDLE;
          end
        end
        S_HVON: begin
          if (hven_fall) begin
            seq_err <= 1'b1;
            abort_q <= 1'b1;
            st <= S_RECOV;
            cnt <= CW'(1);
          end else if (erase_fall) begin
            if (cnt < ers_need) seq_err <= 1'b1;
            else if (!abort_q) erase_strobe <= 1'b1;
            st <= S_EOFF;
            cnt <= CW'(1);
          end
        end
        S_EOFF: begin
          if (hven_fall) begin
            if (cnt < NVH_C) seq_err <= 1'b1;
            st <= S_RECOV;
            cnt <= CW'(1);
          end
        end
        S_RECOV: begin
          if (cnt >= RCV_C) begin
            st <= S_IDLE;
            abort_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic in_page(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] l);
    logic av, lv;
    av = a >= VB;
    lv = l >= VB;
    return lv ? av : (!av && a[ADDR_W-1:6] == l[ADDR_W-1:6]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= {1'b0, 7'(i)};
    end else if (erase_strobe) begin
      for (int i = 0; i < DEPTH; i++)
        if (mass_q || in_page(ADDR_W'(i), la)) mem[i] <= 8'hFF;
    end
  end

  p_interlock_r3: assert property (@(posedge clk) disable iff (!rst_n) !(pgm_q && erase_q));
  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n) seq_err |=> seq_err);
  p_strobe_phase_r8: assert property (@(posedge clk) disable iff (!rst_n) erase_strobe |-> (busy && !erase_q));
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) erase_strobe |=> !erase_strobe);
  p_read_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && busy) |-> (rd_blocked && arr_rdata == 8'hFF));
  p_busy_after_hv_r11: assert property (@(posedge clk) disable iff (!rst_n) $rose(hven_q) |-> busy);

endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  localparam int PERIOD = 10;
  localparam int NVS = 10, ERS_S = 1000, ERS_L = 4000, NVH = 5, DEPTH = 1024;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0, arr_wr = 0, arr_rd = 0;
  logic [4:0] reg_wdata = 0;
  logic [9:0] arr_addr = 0;
  logic [7:0] reg_rdata, arr_rdata;
  logic rd_blocked, busy, seq_err, erase_strobe;
  int checks = 0, errors = 0;
  bit done = 0;

  flash_erase_seq u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata,
    .arr_wr, .arr_rd, .arr_addr, .arr_rdata, .rd_blocked, .busy, .seq_err, .erase_strobe);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int a);
    return {1'b0, 7'(a)};
  endfunction

  task automatic idle(input int k); repeat (k) @(negedge clk); endtask
  task automatic do_reset(); rst_n = 0; idle(2); rst_n = 1; idle(1); endtask
  task automatic cw(input logic [4:0] v);
    reg_sel = 0; reg_wdata = v; reg_wr = 1; @(negedge clk); reg_wr = 0;
  endtask
  task automatic prd(); reg_sel = 1; reg_rd = 1; @(negedge clk); reg_rd = 0; reg_sel = 0; endtask
  task automatic aw(input int a); arr_addr = 10'(a); arr_wr = 1; @(negedge clk); arr_wr = 0; endtask
  task automatic ar(input int a, output logic [7:0] d, output logic b);
    arr_addr = 10'(a); arr_rd = 1; #1; d = arr_rdata; b = rd_blocked; arr_rd = 0;
  endtask
  task automatic rreg(input logic s, output logic [7:0] d);
    reg_sel = s; #1; d = reg_rdata; reg_sel = 0;
  endtask
  task automatic chk_byte(input string tag, input int a, input int exp);
    logic [7:0] d; logic b;
    ar(a, d, b); chk(tag, d, exp);
  endtask

  task automatic erase_seq(input int a, input logic [4:0] e, input int g1, input int g2, input int g3);
    cw(e); prd(); aw(a); idle(g1 - 1);
    cw(e | 5'h08); idle(g2 - 1);
    cw((e & 5'h1D) | 5'h08); idle(g3 - 1);
    cw(5'h00); idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rreg(0, d); chk("R1 ctrl", d, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", seq_err, 0);
    chk_byte("R1 array", 10'h085, 8'h05);
    rreg(1, d); chk("R2 protect", d, 8'hFE);
  endtask

  task automatic t_interlock();
    logic [7:0] d;
    do_reset();
    cw(5'h02); rreg(0, d); chk("R2 erase bit1", d, 8'h02);
    cw(5'h03); rreg(0, d); chk("R3 keep erase", d, 8'h02);
    cw(5'h00); cw(5'h03); rreg(0, d); chk("R3 both new", d, 8'h00);
    cw(5'h01); cw(5'h03); rreg(0, d); chk("R3 keep pgm", d, 8'h01);
    cw(5'h1C); rreg(0, d); chk("R2 fields", d, 8'h1C);
    cw(5'h00);
  endtask

  task automatic t_page();
    logic [7:0] d; logic b; int bad;
    do_reset();
    cw(5'h02);
    ar(10'h010, d, b); chk("R12 read between steps", d, 8'h10);
    prd(); aw(10'h09A);
    rreg(0, d); ar(10'h011, d, b);
    chk("R12 read before hv", d, 8'h11);
    idle(NVS - 1); cw(5'h0A);
    chk("R11 busy on hv", busy, 1);
    ar(10'h090, d, b);
    chk("R11 blocked data", d, 8'hFF);
    chk("R11 blocked flag", b, 1);
    idle(ERS_S - 1); cw(5'h08);
    chk("R8 strobe", erase_strobe, 1);
    idle(NVH - 1); cw(5'h00);
    chk("R11 recovery busy", busy, 1);
    idle(1);
    chk("R11 busy done", busy, 0);
    chk("R5 no err at minimum", seq_err, 0);
    bad = 0;
    for (int a = 10'h080; a < 10'h0C0; a++) begin ar(a, d, b); if (d != 8'hFF) bad++; end
    chk("R8 page bytes", bad, 0);
    chk_byte("R8 below page", 10'h07F, 8'h7F);
    chk_byte("R8 above page", 10'h0C0, 8'h40);
  endtask

  task automatic t_early_hv();
    do_reset();
    erase_seq(10'h080, 5'h02, NVS - 1, ERS_S, NVH);
    chk("R5 err", seq_err, 1);
    chk_byte("R5 no erase", 10'h080, 8'h00);
    erase_seq(10'h080, 5'h02, NVS, ERS_S, NVH);
    chk("R13 sticky", seq_err, 1);
    chk_byte("R13 later erase", 10'h080, 8'hFF);
  endtask

  task automatic t_short_ers();
    do_reset();
    erase_seq(10'h100, 5'h02, NVS, ERS_S - 1, NVH);
    chk("R6 short err", seq_err, 1);
    chk_byte("R6 short no erase", 10'h101, 8'h01);
  endtask

  task automatic t_long();
    do_reset();
    erase_seq(10'h140, 5'h12, NVS, ERS_S, NVH);
    chk("R6 long err", seq_err, 1);
    chk_byte("R6 long no erase", 10'h140, 8'h40);
    do_reset();
    erase_seq(10'h140, 5'h12, NVS, ERS_L, NVH);
    chk("R6 long ok", seq_err, 0);
    chk_byte("R6 long erased", 10'h17F, 8'hFF);
  endtask

  task automatic t_nvh();
    do_reset();
    erase_seq(10'h200, 5'h02, NVS, ERS_S, NVH - 1);
    chk("R7 err", seq_err, 1);
    chk_byte("R7 erase kept", 10'h200, 8'hFF);
  endtask

  task automatic t_order();
    do_reset();
    cw(5'h02); aw(10'h040); idle(20); cw(5'h0A); idle(ERS_S); cw(5'h08); idle(NVH); cw(5'h00); idle(3);
    chk("R4 skip protect err", seq_err, 1);
    chk_byte("R4 no erase", 10'h040, 8'h40);
  endtask

  task automatic t_mass();
    logic [7:0] d; logic b; int bad;
    do_reset();
    erase_seq(10'h005, 5'h06, NVS, ERS_S, NVH);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin ar(a, d, b); if (d != 8'hFF) bad++; end
    chk("R10 mass", bad, 0);
  endtask

  task automatic t_vector();
    do_reset();
    erase_seq(10'h3E0, 5'h02, NVS, ERS_S, NVH);
    chk_byte("R9 trim byte", 10'h3D0, 8'hFF);
    chk_byte("R9 top byte", 10'h3FF, 8'hFF);
    chk_byte("R9 below vector", 10'h3CF, 8'h4F);
    do_reset();
    erase_seq(10'h3C5, 5'h02, NVS, ERS_S, NVH);
    chk_byte("R9 short page", 10'h3CF, 8'hFF);
    chk_byte("R9 trim kept", 10'h3D0, 8'h50);
  endtask

  task automatic t_ignored();
    do_reset();
    aw(10'h003); idle(2);
    chk_byte("R12 idle write ignored", 10'h003, 8'h03);
    chk("R12 no err", seq_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_interlock();
    t_page();
    t_early_hv();
    t_short_ers();
    t_long();
    t_nvh();
    t_order();
    t_mass();
    t_vector();
    t_ignored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule